// File: doc/BRIEF.md
# HDLC Receive Link Monitor with Event Interrupts

This block observes one serial HDLC data link channel, taking one line bit per cycle in which the bit strobe is high. Bits arrive least significant bit first. The block finds flag octets and abort runs in the raw stream. Inside a frame it removes the zeros that the transmitter inserted, groups the remaining bits into octets and runs a CRC-16 over them. From this it reports the start of reception, the end of reception and a frame check error on the closing flag.

Two more events, start and end of transmission, arrive as single-cycle pulses from a transmitter outside the block. All seven events are kept in a sticky status register, and each read of that register clears it. A separate enable register, with one bit per event at the same bit position, decides which of the set status bits drive the single interrupt line. Software reaches both registers through a plain read/write port with combinational read data.

Top module: `hdlc_link_mon`

## Requirements
- R1: Every time the last eight raw line bits form the octet 0x7E, status bit 0 (idle) is set.
- R2: Status bit 1 (abort) is set on the seventh consecutive raw 1 bit.
- R3: A read with `reg_addr_i` = 0 returns the status register in bits 6:0, with bit 7 reading 0. The status register is cleared to 0 on the next edge.
- R4: An event that arrives in the same cycle as a status read is not lost. Its bit reads 1 on the following status read.
- R5: The enable register sits at `reg_addr_i` = 1. It resets to 0, and bits 6:0 are read/write while bit 7 always reads 0. Enable bit k masks status bit k.
- R6: `irq_o` is high exactly while some status bit and its enable bit are both 1.
- R7: After a flag, the first complete octet that is not itself a flag sets status bit 5 (receive start). Back-to-back flags do not set it.
- R8: A flag that closes a frame in progress sets status bit 3 (receive end), along with the idle bit.
- R9: Inside a frame, a 0 that follows five consecutive 1s is dropped before octet assembly and CRC. A correctly stuffed frame therefore reports no FCS error.
- R10: At the closing flag, status bit 2 (FCS error) is set if the CRC-16 has a residue other than 0xF0B8. The CRC uses polynomial x^16+x^12+x^5+1, is preset to 0xFFFF, and covers all data and FCS octets.
- R11: An abort drops the current frame. The next flag reports idle only, with no receive end and no FCS error.
- R12: A pulse on `tx_sot_i` sets status bit 6, and a pulse on `tx_eot_i` sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Line bit strobe |
| bit_i | input | 1 | Line bit, valid while bit_en_i is high |
| tx_sot_i | input | 1 | Pulse from the transmitter at the start of transmission |
| tx_eot_i | input | 1 | Pulse from the transmitter at the end of transmission |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 selects status, 1 selects enable |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The status read that clears the sticky bits can fall in the same cycle as a new event. The bench provokes this by asserting a status read and a transmit start pulse together. It expects the read to return the old value (0) and the next read to show bit 6 set. A second overlap happens inside the receiver: at a closing flag, idle, receive end and FCS error are raised together. The bench checks this by comparing whole status words after a good frame and after a frame with a corrupted check sequence.

// File: rtl/hdlc_mon_pkg.sv
package hdlc_mon_pkg;
  localparam int NUM_EV   = 7;
  localparam int EV_IDLE  = 0;
  localparam int EV_ABORT = 1;
  localparam int EV_FCS   = 2;
  localparam int EV_RXEOT = 3;
  localparam int EV_TXEOT = 4;
  localparam int EV_RXSOT = 5;
  localparam int EV_TXSOT = 6;

  localparam logic ADDR_STS = 1'b0;
  localparam logic ADDR_ENA = 1'b1;

  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/hdlc_bit_rx.sv
module hdlc_bit_rx #(
  parameter int FLAG_W     = 8,
  parameter logic [FLAG_W-1:0] FLAG = 8'h7E,
  parameter int ABORT_ONES = 7,
  parameter int STUFF_ONES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic flag_o,
  output logic abort_o,
  output logic dvalid_o,
  output logic dbit_o
);
  localparam int CNT_W = $clog2(ABORT_ONES + 1);

  logic [FLAG_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  ones_q;

  assign sh_n     = {bit_i, sh_q[FLAG_W-1:1]};
  assign flag_o   = bit_en_i && (sh_n == FLAG);
  assign abort_o  = bit_en_i && bit_i && (ones_q == CNT_W'(ABORT_ONES - 1));
  // stuffed zero: dropped from the data stream
  assign dvalid_o = bit_en_i && !(!bit_i && (ones_q == CNT_W'(STUFF_ONES)));
  assign dbit_o   = bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      ones_q <= '0;
    end else if (bit_en_i) begin
      sh_q <= sh_n;
      if (!bit_i)                                 ones_q <= '0;
      else if (ones_q != CNT_W'(ABORT_ONES))      ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx #(
  parameter int OCT_W = 8,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_GOOD = 16'hF0B8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  input  logic abort_i,
  input  logic dvalid_i,
  input  logic dbit_i,
  output logic sot_o,
  output logic eot_o,
  output logic fcs_err_o
);
  localparam int CNT_W = $clog2(OCT_W);

  logic [OCT_W-1:0] acc_q, acc_n;
  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] crc_q;
  logic             synced_q, in_frame_q, oct_done;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [OCT_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c ^ CRC_W'(d);
    for (int i = 0; i < OCT_W; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  assign acc_n     = {dbit_i, acc_q[OCT_W-1:1]};
  assign oct_done  = !abort_i && !flag_i && synced_q && dvalid_i &&
                     (cnt_q == CNT_W'(OCT_W - 1));
  assign sot_o     = oct_done && !in_frame_q;
  assign eot_o     = flag_i && in_frame_q;
  assign fcs_err_o = eot_o && (crc_q != CRC_GOOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      cnt_q      <= '0;
      crc_q      <= CRC_INIT;
      synced_q   <= 1'b0;
      in_frame_q <= 1'b0;
    end else if (abort_i) begin
      synced_q   <= 1'b0;
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (flag_i) begin
      synced_q   <= 1'b1;
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (synced_q && dvalid_i) begin
      acc_q <= acc_n;
      cnt_q <= oct_done ? '0 : cnt_q + 1'b1;
      if (oct_done) begin
        in_frame_q <= 1'b1;
        crc_q      <= crc_step(in_frame_q ? crc_q : CRC_INIT, acc_n);
      end
    end
  end
endmodule

// File: rtl/hdlc_irq_regs.sv
module hdlc_irq_regs
  import hdlc_mon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  ev_vec_t           ev_i,
  output logic [DATA_W-1:0] rdata_o,
  output ev_vec_t           sts_o,
  output logic [DATA_W-1:0] ena_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] ENA_MASK = DATA_W'((1 << NUM_EV) - 1);

  ev_vec_t           sts_q;
  logic [DATA_W-1:0] ena_q, sts_ext;
  logic              rd_clr;

  assign rd_clr = rd_i && (addr_i == ADDR_STS);

  for (genvar k = 0; k < NUM_EV; k++) begin : g_sticky
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q[k] <= 1'b0;
      else         sts_q[k] <= ev_i[k] | (sts_q[k] & !rd_clr);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ena_q <= '0;
    else if (wr_i && addr_i == ADDR_ENA)   ena_q <= wdata_i & ENA_MASK;
  end

  assign sts_ext = DATA_W'(sts_q);
  assign rdata_o = (addr_i == ADDR_ENA) ? ena_q : sts_ext;
  assign irq_o   = |(sts_ext & ena_q);
  assign sts_o   = sts_q;
  assign ena_o   = ena_q;
endmodule

// File: rtl/hdlc_link_mon.sv
module hdlc_link_mon
  import hdlc_mon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              tx_sot_i,
  input  logic              tx_eot_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic    flag_w, abort_w, dvalid_w, dbit_w, sot_w, eot_w, fcs_w;
  ev_vec_t ev_w, sts_w;
  logic [DATA_W-1:0] ena_w;

  hdlc_bit_rx u_bit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_en_i(bit_en_i),
    .bit_i   (bit_i),
    .flag_o  (flag_w),
    .abort_o (abort_w),
    .dvalid_o(dvalid_w),
    .dbit_o  (dbit_w)
  );

  hdlc_frame_rx u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flag_i   (flag_w),
    .abort_i  (abort_w),
    .dvalid_i (dvalid_w),
    .dbit_i   (dbit_w),
    .sot_o    (sot_w),
    .eot_o    (eot_w),
    .fcs_err_o(fcs_w)
  );

  always_comb begin
    ev_w           = '0;
    ev_w[EV_IDLE]  = flag_w;
    ev_w[EV_ABORT] = abort_w;
    ev_w[EV_FCS]   = fcs_w;
    ev_w[EV_RXEOT] = eot_w;
    ev_w[EV_TXEOT] = tx_eot_i;
    ev_w[EV_RXSOT] = sot_w;
    ev_w[EV_TXSOT] = tx_sot_i;
  end

  hdlc_irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (reg_rd_i),
    .wr_i   (reg_wr_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .ev_i   (ev_w),
    .rdata_o(reg_rdata_o),
    .sts_o  (sts_w),
    .ena_o  (ena_w),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/hdlc_link_mon_chk.sv
module hdlc_link_mon_chk
  import hdlc_mon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_rd_i,
  input logic              reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              tx_sot_i,
  input logic              irq_o,
  input ev_vec_t           ev_i,
  input ev_vec_t           sts_i,
  input logic [DATA_W-1:0] ena_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_STS && ev_i == '0) |=> (sts_i == '0));

  a_r4_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> ((sts_i & $past(ev_i)) == $past(ev_i)));

  a_r5_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_ENA) |-> (reg_rdata_o[DATA_W-1] == 1'b0));

  a_r6_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i == '0) |-> !irq_o);

  a_r8_eot_on_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i[EV_RXEOT] |-> ev_i[EV_IDLE]);

  a_r10_fcs_at_eot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i[EV_FCS] |-> ev_i[EV_RXEOT]);

  a_r11_abort_no_eot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i[EV_ABORT] |-> !ev_i[EV_RXEOT]);

  a_r12_tx_sot_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sot_i |=> sts_i[EV_TXSOT]);
endmodule

bind hdlc_link_mon hdlc_link_mon_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_rd_i   (reg_rd_i),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .tx_sot_i   (tx_sot_i),
  .irq_o      (irq_o),
  .ev_i       (ev_w),
  .sts_i      (sts_w),
  .ena_i      (ena_w)
);

// File: tb/hdlc_link_mon_tb.sv
module hdlc_link_mon_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, bit_d = 1'b0;
  logic       tx_sot = 1'b0, tx_eot = 1'b0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0, n_fail = 0, tx_ones = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  hdlc_link_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_d),
    .tx_sot_i(tx_sot), .tx_eot_i(tx_eot), .reg_rd_i(reg_rd), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries on every read
  initial forever begin
    @(negedge clk);
    #(CLK_P/4);
    if (reg_rd && exp_q.size() > 0) check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
  end

  task automatic rd_reg(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_ena(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    #(CLK_P/4);
    check(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic send_raw(input logic b);
    @(negedge clk);
    bit_en = 1'b1; bit_d = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_raw(i != 0 && i != 7);
    tx_ones = 0;
  endtask

  task automatic send_data(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      send_raw(v[i]);
      if (v[i]) begin
        tx_ones++;
        if (tx_ones == 5) begin send_raw(1'b0); tx_ones = 0; end
      end else tx_ones = 0;
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic send_frame(input logic [7:0] b0, b1, b2, input logic bad);
    logic [15:0] c = 16'hFFFF;
    send_flag();
    send_data(b0); c = crc_byte(c, b0);
    send_data(b1); c = crc_byte(c, b1);
    send_data(b2); c = crc_byte(c, b2);
    c = ~c ^ {15'd0, bad};
    send_data(c[7:0]);
    send_data(c[15:8]);
    send_flag();
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_reg(1'b0, 8'h00, "R3 reset status");
    rd_reg(1'b1, 8'h00, "R5 reset enable");
    chk_irq(1'b0, "R6 reset irq");

    send_flag();
    rd_reg(1'b0, 8'h01, "R1 idle on flag");
    rd_reg(1'b0, 8'h00, "R3 cleared by read");

    wr_ena(8'hFF);
    rd_reg(1'b1, 8'h7F, "R5 enable bit7 reads 0");
    wr_ena(8'h00);

    // 0xFF and 0x3E force stuffed zeros
    send_frame(8'h12, 8'hFF, 8'h3E, 1'b0);
    rd_reg(1'b0, 8'h29, "R7/R8/R9 good frame");

    send_frame(8'h12, 8'hFF, 8'h3E, 1'b1);
    rd_reg(1'b0, 8'h2D, "R10 bad FCS");

    send_flag();
    send_data(8'h55);
    send_data(8'hAA);
    for (int i = 0; i < 7; i++) send_raw(1'b1);
    rd_reg(1'b0, 8'h23, "R2 abort inside frame");
    send_flag();
    rd_reg(1'b0, 8'h01, "R11 no end after abort");

    send_flag();
    send_flag();
    rd_reg(1'b0, 8'h01, "R7 back-to-back flags no start");

    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 1'b0; tx_sot = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R4 read with event");
    @(negedge clk);
    reg_rd = 1'b0; tx_sot = 1'b0;
    rd_reg(1'b0, 8'h40, "R4/R12 event kept");

    wr_ena(8'h40);
    @(negedge clk); tx_eot = 1'b1;
    @(negedge clk); tx_eot = 1'b0;
    chk_irq(1'b0, "R6 masked irq");
    wr_ena(8'h10);
    chk_irq(1'b1, "R6 enabled irq");
    rd_reg(1'b0, 8'h10, "R12 tx end");
    chk_irq(1'b0, "R6 irq drops after read");

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule